// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block merges thirteen level-sensitive interrupt request lines, numbered 1 to 13, into one request toward a processor. Each line is captured into a pending register every cycle. A mask register can block any line. Each line has an 8-bit control register that holds a 5-bit arbitration priority and an autovector select, and an 8-bit vector register. Every cycle the controller picks one winner among the lines that are pending and not masked. The winner is the line with the strictly greatest priority, and the lower line number breaks a tie. A priority of zero never wins.

The processor-side outputs are a valid flag, a 3-bit interrupt level and an 8-bit vector. The level is the top three bits of the winner's priority. The vector is either a fixed autovector (24 plus the level) or the winner's programmed vector. These outputs are registered. They describe only the current winner. Acknowledge cycles are handled elsewhere.

A simple synchronous register port gives write access to the mask, control and vector registers, and combinational read access to those registers and to the pending register. Address bits [5:4] select a space: 0 is miscellaneous, 1 is control, 2 is vector. Address bits [3:0] select the register within that space. Typical source wiring puts two timers on lines 9 and 10 and two serial ports on lines 12 and 13.

Top module: `prio_intc`

## Requirements
- R1: A line takes part in arbitration only when its pending bit is 1 and its mask bit is 0. The mask lives at address 0x00, bit n for line n. A mask bit of 1 blocks the line.
- R2: Line 0 does not exist. Input src_req[0] never causes a request, and pending bit 0 always reads 0.
- R3: Among the active lines, the winner is the one whose control bits [4:0] hold the strictly greatest value. An active line with priority 0 never wins.
- R4: When active lines share the greatest priority, the lowest-numbered of them wins.
- R5: irq_level equals bits [4:2] of the winner's control register.
- R6: Each pending bit copies its input line at every clock edge, so it sets while the line is high and clears once the line drops. The pending register reads at address 0x01. Writes to it are ignored.
- R7: If the winner's control bit 7 is 1, irq_vector is 24 plus irq_level. Otherwise irq_vector is the winner's vector register, at address 0x20+n.
- R8: With no winner, irq_valid, irq_level and irq_vector are all 0.
- R9: The outputs are registered. A write to a control or mask register, or a pending update, appears at the outputs after the next clock edge, and the outputs do not change when nothing changes.
- R10: Control register n reads and writes at address 0x10+n, and vector register n at 0x20+n, both as 8 bits. Index 0, index 14, index 15 and space 3 read 0 and ignore writes.
- R11: After reset the mask is all ones (reads 0x3FFF). Pending, control, vector and the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 14 | Request lines; bit n is line n, bit 0 unused |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: [5:4] space, [3:0] index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| irq_valid | output | 1 | A line is winning arbitration |
| irq_level | output | 3 | Processor interrupt level of the winner |
| irq_vector | output | 8 | Vector number of the winner |

## Verification
In the first setting every line has a distinct priority, one line has priority zero, and odd lines are autovectored. All 16384 request patterns are applied with no mask. This sweep separates the strict-maximum choice, the zero-priority exclusion and the two vector sources.

In the second setting priorities fall into three shared classes and the mask changes with every pattern. That sweep tells the lowest-number tie rule apart from any other order, and shows that masked lines are skipped.

Directed cases cover the following:
- line 0 alone;
- the one-cycle output latency after a control write;
- pending readback and ignored pending writes;
- unmapped addresses.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int PRIO_W       = 5;   // arbitration priority width
    localparam int LVL_W        = 3;   // processor level width
    localparam int LVL_LSB      = 2;   // level sits in priority bits [4:2]
    localparam int VEC_W        = 8;   // vector number width
    localparam int CTRL_W       = 8;   // per-line control register width
    localparam int AUTOVEC_BIT  = 7;   // control bit selecting autovector
    localparam int AUTOVEC_BASE = 24;  // autovector = base + level

    localparam logic [1:0] SPACE_MISC = 2'd0;
    localparam logic [1:0] SPACE_CTRL = 2'd1;
    localparam logic [1:0] SPACE_VEC  = 2'd2;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } irq_out_t;

endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = 4,
    parameter int DATA_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC:0]                src_req,
    input  logic                            reg_we,
    input  logic [IDX_W+1:0]                reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    output logic [NUM_SRC:0]                pend_o,
    output logic [NUM_SRC:0]                mask_o,
    output logic [NUM_SRC:0]                active_o,
    output logic [NUM_SRC:1][CTRL_W-1:0]    ctrl_o,
    output logic [NUM_SRC:1][VEC_W-1:0]     vec_o
);

    typedef struct packed {
        logic [NUM_SRC:0]             mask;
        logic [NUM_SRC:0]             pend;
        logic [NUM_SRC:1][CTRL_W-1:0] ctrl;
        logic [NUM_SRC:1][VEC_W-1:0]  vec;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic [1:0]       space;
    logic [IDX_W-1:0] idx;
    logic             unused_in;

    assign space     = reg_addr[IDX_W+1:IDX_W];
    assign idx       = reg_addr[IDX_W-1:0];
    assign unused_in = ^{reg_wdata[DATA_W-1:NUM_SRC+1], src_req[0]};

    // next-state: pending copies lines 1..N, register writes by space
    always_comb begin
        st_d      = st_q;
        st_d.pend = {src_req[NUM_SRC:1], 1'b0};
        if (reg_we) begin
            case (space)
                SPACE_MISC: begin
                    if (idx == IDX_W'(0)) begin
                        st_d.mask = reg_wdata[NUM_SRC:0];
                    end
                end
                SPACE_CTRL: begin
                    for (int n = 1; n <= NUM_SRC; n++) begin
                        if (idx == IDX_W'(n)) begin
                            st_d.ctrl[n] = reg_wdata[CTRL_W-1:0];
                        end
                    end
                end
                SPACE_VEC: begin
                    for (int n = 1; n <= NUM_SRC; n++) begin
                        if (idx == IDX_W'(n)) begin
                            st_d.vec[n] = reg_wdata[VEC_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (space)
            SPACE_MISC: begin
                if (idx == IDX_W'(0)) begin
                    reg_rdata = DATA_W'(st_q.mask);
                end else if (idx == IDX_W'(1)) begin
                    reg_rdata = DATA_W'(st_q.pend);
                end
            end
            SPACE_CTRL: begin
                for (int n = 1; n <= NUM_SRC; n++) begin
                    if (idx == IDX_W'(n)) begin
                        reg_rdata = DATA_W'(st_q.ctrl[n]);
                    end
                end
            end
            SPACE_VEC: begin
                for (int n = 1; n <= NUM_SRC; n++) begin
                    if (idx == IDX_W'(n)) begin
                        reg_rdata = DATA_W'(st_q.vec[n]);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mask: '1, pend: '0, ctrl: '0, vec: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o   = st_q.pend;
    assign mask_o   = st_q.mask;
    assign active_o = st_q.pend & ~st_q.mask;
    assign ctrl_o   = st_q.ctrl;
    assign vec_o    = st_q.vec;

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC:0]             active,
    input  logic [NUM_SRC:1][CTRL_W-1:0] ctrl,
    output logic [IDX_W-1:0]             win_idx,
    output logic                         win_found
);

    logic [PRIO_W-1:0] best;
    logic              unused_bits;

    // upward scan; replace only on strictly greater priority
    always_comb begin
        best    = '0;
        win_idx = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (active[n] && (ctrl[n][PRIO_W-1:0] > best)) begin
                best    = ctrl[n][PRIO_W-1:0];
                win_idx = IDX_W'(n);
            end
        end
        win_found = (win_idx != '0);
    end

    always_comb begin
        unused_bits = active[0];
        for (int n = 1; n <= NUM_SRC; n++) begin
            unused_bits = unused_bits ^ (^ctrl[n][CTRL_W-1:PRIO_W]);
        end
    end

endmodule

// File: rtl/prio_intc_vec.sv
module prio_intc_vec
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int IDX_W   = 4
) (
    input  logic [IDX_W-1:0]             win_idx,
    input  logic                         win_found,
    input  logic [NUM_SRC:1][CTRL_W-1:0] ctrl,
    input  logic [NUM_SRC:1][VEC_W-1:0]  vec,
    output irq_out_t                     nxt
);

    logic [CTRL_W-1:0] sel_ctrl;
    logic [VEC_W-1:0]  sel_vec;
    logic [LVL_W-1:0]  lvl;
    logic              unused_ctrl;

    always_comb begin
        sel_ctrl = '0;
        sel_vec  = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (win_idx == IDX_W'(n)) begin
                sel_ctrl = ctrl[n];
                sel_vec  = vec[n];
            end
        end
    end

    assign lvl         = sel_ctrl[LVL_LSB+LVL_W-1:LVL_LSB];
    assign unused_ctrl = ^{sel_ctrl[AUTOVEC_BIT-1:LVL_LSB+LVL_W], sel_ctrl[LVL_LSB-1:0]};

    always_comb begin
        nxt = '0;
        if (win_found) begin
            nxt.valid  = 1'b1;
            nxt.level  = lvl;
            nxt.vector = sel_ctrl[AUTOVEC_BIT] ? (VEC_W'(AUTOVEC_BASE) + VEC_W'(lvl)) : sel_vec;
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter  int NUM_SRC = 13,
    parameter  int DATA_W  = 16,
    localparam int IDX_W   = $clog2(NUM_SRC + 1),
    localparam int ADDR_W  = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:0]   src_req,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_valid,
    output logic [LVL_W-1:0]   irq_level,
    output logic [VEC_W-1:0]   irq_vector
);

    logic [NUM_SRC:0]             pend_w;
    logic [NUM_SRC:0]             mask_w;
    logic [NUM_SRC:0]             active_w;
    logic [NUM_SRC:1][CTRL_W-1:0] ctrl_w;
    logic [NUM_SRC:1][VEC_W-1:0]  vec_w;
    logic [IDX_W-1:0]             win_idx_w;
    logic                         win_found_w;
    irq_out_t                     nxt_w;
    irq_out_t                     out_d, out_q;

    prio_intc_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pend_o    (pend_w),
        .mask_o    (mask_w),
        .active_o  (active_w),
        .ctrl_o    (ctrl_w),
        .vec_o     (vec_w)
    );

    prio_intc_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .active    (active_w),
        .ctrl      (ctrl_w),
        .win_idx   (win_idx_w),
        .win_found (win_found_w)
    );

    prio_intc_vec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_vec (
        .win_idx   (win_idx_w),
        .win_found (win_found_w),
        .ctrl      (ctrl_w),
        .vec       (vec_w),
        .nxt       (nxt_w)
    );

    always_comb begin
        out_d = nxt_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_valid  = out_q.valid;
    assign irq_level  = out_q.level;
    assign irq_vector = out_q.vector;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int NUM_SRC = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_SRC:0] src_req,
    input logic             reg_we,
    input logic             irq_valid,
    input logic [2:0]       irq_level,
    input logic [7:0]       irq_vector,
    input logic [NUM_SRC:0] pend,
    input logic [NUM_SRC:0] mask
);

    AST_VALID_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ($past(pend & ~mask) != '0)); // R1

    AST_NO_LINE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_req[NUM_SRC:1], 2) == '0) |-> !irq_valid); // R2

    AST_PEND_TRACKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        pend[NUM_SRC:1] == $past(src_req[NUM_SRC:1])); // R6

    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_level == 3'd0 && irq_vector == 8'd0)); // R8

    AST_QUIET_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(src_req, 2) == $past(src_req, 3)) && !$past(reg_we, 2))
        |-> ($stable(irq_valid) && $stable(irq_level) && $stable(irq_vector))); // R9

endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .reg_we     (reg_we),
    .irq_valid  (irq_valid),
    .irq_level  (irq_level),
    .irq_vector (irq_vector),
    .pend       (pend_w),
    .mask       (mask_w)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] src_req;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq_valid;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  ctl_m [14];
    logic [7:0]  vec_m [14];
    logic [13:0] mask_m;

    always #2.5 clk = ~clk;

    prio_intc i_prio_intc (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_valid  (irq_valid),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ctl(input int n, input logic [7:0] c, input logic [7:0] v);
        ctl_m[n] = c;
        vec_m[n] = v;
        wr(6'h10 + 6'(n), {8'h00, c});
        wr(6'h20 + 6'(n), {8'h00, v});
    endtask

    task automatic set_mask(input logic [13:0] m);
        mask_m = m;
        wr(6'h00, {2'b00, m});
    endtask

    function automatic logic [11:0] model(input logic [13:0] act);
        logic [4:0] best = 5'd0;
        int         win  = 0;
        logic [2:0] lvl;
        for (int n = 1; n <= 13; n++) begin
            if (act[n] && ctl_m[n][4:0] > best) begin
                best = ctl_m[n][4:0];
                win  = n;
            end
        end
        if (win == 0) return 12'h000;
        lvl = ctl_m[win][4:2];
        return {1'b1, lvl, ctl_m[win][7] ? (8'd24 + {5'd0, lvl}) : vec_m[win]};
    endfunction

    function automatic logic [15:0] outs();
        return {4'h0, irq_valid, irq_level, irq_vector};
    endfunction

    task automatic apply(input logic [13:0] p, input string tag);
        @(negedge clk);
        src_req = p;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(tag, outs(), {4'h0, model(p & ~mask_m & 14'h3FFE)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst_n     = 1'b0;
        src_req   = '0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        mask_m    = 14'h3FFF;
        for (int n = 0; n < 14; n++) begin
            ctl_m[n] = 8'h00;
            vec_m[n] = 8'h00;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        check("R11 outputs", outs(), 16'h0000);
        rd(6'h00, d); check("R11 mask", d, 16'h3FFF);
        rd(6'h01, d); check("R11 pending", d, 16'h0000);
        rd(6'h11, d); check("R11 ctrl1", d, 16'h0000);
        rd(6'h2D, d); check("R11 vec13", d, 16'h0000);

        // configuration A: distinct priorities, line 5 priority 0, odd lines autovector
        for (int n = 1; n <= 13; n++) begin
            logic [7:0] c;
            c = 8'((n * 7) % 32);
            if (n == 5) c = 8'h00;
            if (n % 2 == 1) c = c | 8'h80;
            set_ctl(n, c, 8'h40 + 8'(n));
        end

        // R10 readback and unmapped addresses
        rd(6'h13, d); check("R10 ctrl3", d, {8'h00, ctl_m[3]});
        rd(6'h27, d); check("R10 vec7", d, {8'h00, vec_m[7]});
        rd(6'h10, d); check("R10 ctrl index0", d, 16'h0000);
        rd(6'h1F, d); check("R10 ctrl index15", d, 16'h0000);
        rd(6'h30, d); check("R10 space3", d, 16'h0000);
        rd(6'h02, d); check("R10 misc index2", d, 16'h0000);
        wr(6'h1E, 16'h00FF);
        rd(6'h1E, d); check("R10 write index14 ignored", d, 16'h0000);

        // R1 all masked after reset
        apply(14'h3FFF, "R1 all masked");
        check("R1 masked no irq", outs(), 16'h0000);
        // R6 pending readback, R2 bit0 reads 0
        rd(6'h01, d); check("R6 R2 pending readback", d, 16'h3FFE);
        wr(6'h01, 16'h0000);
        rd(6'h01, d); check("R6 pending write ignored", d, 16'h3FFE);

        set_mask(14'h0000);

        // R2 line 0 alone
        apply(14'h0001, "R2 line0 alone");
        rd(6'h01, d); check("R2 pending bit0", d, 16'h0000);

        // R3 zero priority line alone
        apply(14'h0020, "R3 zero priority");
        check("R3 zero priority never wins", outs(), 16'h0000);

        // R9 output latency after a control write: line 2 priority 14, level 3, vec 0x42
        apply(14'h0004, "R9 pre");
        check("R5 R7 line2 programmed vector", outs(), {4'h0, 1'b1, 3'd3, 8'h42});
        ctl_m[2] = 8'h9F;
        wr(6'h12, 16'h009F);
        @(negedge clk);
        check("R9 old value before edge", outs(), {4'h0, 1'b1, 3'd3, 8'h42});
        @(posedge clk);
        @(negedge clk);
        check("R9 R7 new autovector", outs(), {4'h0, 1'b1, 3'd7, 8'd31});
        set_ctl(2, 8'h0E, 8'h42);

        // R3 R5 R7 R8 exhaustive sweep in configuration A
        for (int p = 0; p < 16384; p++) begin
            apply(14'(p), "R3 R5 R7 R8 sweep A");
        end

        // configuration B: three shared priority classes, autovector on multiples of 4
        for (int n = 1; n <= 13; n++) begin
            logic [7:0] c;
            c = 8'(8 + 4 * (n % 3));
            if (n % 4 == 0) c = c | 8'h80;
            set_ctl(n, c, 8'h60 + 8'(n));
        end

        // R4 explicit tie: lines 3 and 6 both priority 8
        apply(14'h0048, "R4 tie");
        check("R4 tie lower line wins", outs(), {4'h0, 1'b1, 3'd2, 8'h63});

        // R1 R4 sweep with a changing mask
        for (int p = 0; p < 16384; p += 5) begin
            set_mask(14'((p * 3) ^ 14'h1555));
            apply(14'(p), "R1 R4 sweep B");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule